// File: doc/BRIEF.md
# System Interrupt Router with Level Translation

This block gathers thirty-two level-sensitive device interrupt lines into one pending register, masks them with a disable register, and turns every enabled pending source into a processor interrupt level through a fixed, irregular source-to-level table. Several sources may share one level. The resulting set of levels goes to a single programmable target CPU. Every other CPU receives no hard levels.

Software uses a small word-addressed register bus. It can read pending, read the mask, set and clear mask bits with write-one semantics, and read and write the target CPU. Bit 31 of the disable register is a global kill switch for delivery. A separate broadcast output tells every CPU's local controller that a level-15 source is pending. This output ignores the mask and the target.

Top module: `mirq_router`

## Requirements
- R1: After reset, offset 0x0 reads 0, offset 0x4 reads 0, offset 0x10 reads 0, and every CPU level vector and broadcast bit is 0. Internally the disable register resets to 0x0FA2007F.
- R2: Pending, read at offset 0x0, copies the input lines one clock after they change, with no latching. Sources with level 0 (bits 23 to 26 and 31) never read as pending.
- R3: A write to offset 0x8 clears each disable bit that is written as 1 and lies inside mask 0xF05DFF80. Bits outside that mask keep their value. Sources 0 to 6, 17, 21 and 27 therefore stay disabled after reset.
- R4: A write to offset 0xC sets each disable bit that is written as 1 and lies inside mask 0xF05DFF80. Pending is not changed by this write.
- R5: Offset 0x4 reads the disable register ANDed with 0xF05DFF80.
- R6: Each pending, non-disabled source n sets bit L(n) of the level vector. L for sources 0 to 31 is: 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0.
- R7: Only CPU c, where c equals the target register, gets the level vector on cpu_lvl[c*16 +: 16]. All other CPUs get 0. A target of NCPU or above reaches no CPU.
- R8: A write to offset 0x10 keeps only bits 3:0 of the write data. The next read of 0x10 returns those bits, zero-extended.
- R9: While disable bit 31 is 1, every CPU level vector is 0.
- R10: Each bit of lvl15_bcast is 1 while any of sources 27 to 30 is pending. This holds whatever the mask, the master disable bit or the target.
- R11: Reads of offsets 0x14 to 0x1C return 0. Writes to offsets 0x0, 0x4 and 0x14 to 0x1C change nothing.
- R12: Bit 0 of every CPU level vector is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_in | input | 32 | Device interrupt lines, level sensitive |
| reg_wr | input | 1 | Write strobe for one word |
| reg_addr | input | 5 | Byte offset; bits 1:0 are ignored |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| cpu_lvl | output | NCPU*16 | Hard-level vector for each CPU, bit n = level n |
| lvl15_bcast | output | NCPU | Level-15 source pending, same bit for every CPU |

## Verification
The hardest cases to reach are the disable bits that reset sets but software can never clear. Only a full clear-all write followed by a walk over every source line exposes them, because sources 0 to 6, 17, 21 and 27 must still produce no level. The bench clears the whole mask and then raises one line at a time. At each step it compares the pending read, the target CPU's vector, the other CPUs' vectors and the broadcast bit against its own table. It then repeats the key patterns with the target moved, with the target out of range, and with the master disable bit set.

// File: rtl/mirq_router.sv
module mirq_router #(
  parameter int NCPU = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [31:0]        irq_in,
  input  logic               reg_wr,
  input  logic [4:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NCPU*16-1:0] cpu_lvl,
  output logic [NCPU-1:0]    lvl15_bcast
);
  localparam int          LW        = 16;
  localparam int          TW        = 4;
  localparam logic [31:0] WR_MASK   = 32'hF05DFF80;
  localparam logic [31:0] DIS_INIT  = 32'h0FA2007F;
  localparam logic [31:0] SRC_LIVE  = 32'h787FFFFF;
  localparam logic [31:0] SRC_TOP   = 32'h78000000;

  logic [31:0]   pend, dis, live;
  logic [TW-1:0] tgt;
  logic [LW-1:0] lvls;
  logic [NCPU-1:0] cpu_any;
  logic [2:0]    widx;

  assign widx = reg_addr[4:2];

  function automatic logic [3:0] lvl_of(input int b);
    case (b)
      0, 7:               lvl_of = 4'd2;
      1, 8:               lvl_of = 4'd3;
      2, 9:               lvl_of = 4'd5;
      3, 10:              lvl_of = 4'd7;
      4, 11, 21:          lvl_of = 4'd9;
      5, 12, 22:          lvl_of = 4'd11;
      6, 13, 17:          lvl_of = 4'd13;
      14, 15:             lvl_of = 4'd12;
      16:                 lvl_of = 4'd6;
      18:                 lvl_of = 4'd4;
      19:                 lvl_of = 4'd10;
      20:                 lvl_of = 4'd8;
      27, 28, 29, 30:     lvl_of = 4'd15;
      default:            lvl_of = 4'd0;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      dis  <= DIS_INIT;
      tgt  <= '0;
    end else begin
      pend <= irq_in & SRC_LIVE;
      if (reg_wr) begin
        case (widx)
          3'd2: dis <= dis & ~(reg_wdata & WR_MASK);
          3'd3: dis <= dis | (reg_wdata & WR_MASK);
          3'd4: tgt <= reg_wdata[TW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      3'd0:    reg_rdata = {1'b0, pend[30:0]};
      3'd1:    reg_rdata = dis & WR_MASK;
      3'd4:    reg_rdata = {{(32-TW){1'b0}}, tgt};
      default: reg_rdata = '0;
    endcase
  end

  assign live = pend & ~dis;

  always_comb begin
    lvls = '0;
    for (int b = 0; b < 32; b++)
      if (live[b] && lvl_of(b) != 4'd0) lvls[lvl_of(b)] = 1'b1;
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign cpu_lvl[c*LW +: LW] = (TW'(c) == tgt && !dis[31]) ? lvls : '0;
    assign lvl15_bcast[c]      = |(pend & SRC_TOP);
    assign cpu_any[c]          = |cpu_lvl[c*LW +: LW];

    assert_bit0_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_lvl[c*LW] == 1'b0);
  end

  assert_one_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cpu_any));

  assert_master_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dis[31] |-> cpu_lvl == '0);

  assert_tgt_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && widx == 3'd4) |=> tgt == $past(reg_wdata[TW-1:0]));

  assert_clear_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && widx == 3'd2) |=> (dis & $past(reg_wdata & WR_MASK)) == '0);

  assert_set_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && widx == 3'd3) |=>
      (dis & $past(reg_wdata & WR_MASK)) == $past(reg_wdata & WR_MASK));

  assert_fixed_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> (dis & ~WR_MASK) == $past(dis & ~WR_MASK));
endmodule

// File: tb/tb_mirq_router.sv
module tb_mirq_router;
  localparam int NCPU = 4;
  logic clk = 0, rst_n = 0, reg_wr = 0;
  logic [31:0] irq_in = 0, reg_wdata = 0, reg_rdata;
  logic [4:0]  reg_addr = 0;
  logic [NCPU*16-1:0] cpu_lvl;
  logic [NCPU-1:0] lvl15_bcast;
  int checks = 0, errors = 0;
  logic [31:0] m_dis;
  logic [3:0]  m_tgt;

  always #2.5 clk = ~clk;

  mirq_router #(.NCPU(NCPU)) dut (.*);

  function automatic int tlvl(input int b);
    int t[32] = '{2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,
                  6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0};
    return t[b];
  endfunction

  function automatic logic [15:0] exp_vec(input logic [31:0] p, input logic [31:0] d);
    logic [15:0] v = '0;
    for (int b = 0; b < 32; b++)
      if (p[b] && !d[b] && tlvl(b) != 0) v[tlvl(b)] = 1'b1;
    return v;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a[4:2] == 3'd2) m_dis = m_dis & ~(d & 32'hF05DFF80);
    if (a[4:2] == 3'd3) m_dis = m_dis | (d & 32'hF05DFF80);
    if (a[4:2] == 3'd4) m_tgt = d[3:0];
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic drive(input logic [31:0] v);
    @(negedge clk); irq_in = v; @(negedge clk);
  endtask

  task automatic chk_outs(input string req);
    logic [31:0] p = irq_in & 32'h787FFFFF;
    for (int c = 0; c < NCPU; c++)
      chk(req, cpu_lvl[c*16 +: 16],
          (c == m_tgt && !m_dis[31]) ? exp_vec(p, m_dis) : 16'h0);
    chk({req, " bcast"}, lvl15_bcast, (|(p & 32'h78000000)) ? {NCPU{1'b1}} : '0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(5'h00, d); chk("R1 pend", d, 0);
    rd(5'h04, d); chk("R1 mask", d, 0);
    rd(5'h10, d); chk("R1 tgt", d, 0);
    chk("R1 lvl", cpu_lvl, 0);
    chk("R1 bcast", lvl15_bcast, 0);
  endtask

  task automatic t_walk;
    logic [31:0] d;
    wr(5'h08, 32'hFFFFFFFF);
    rd(5'h04, d); chk("R3 clear all", d, 0);
    for (int b = 0; b < 32; b++) begin
      drive(32'h1 << b);
      rd(5'h00, d); chk("R2 pend", d, (32'h1 << b) & 32'h787FFFFF);
      chk_outs("R6 walk");
    end
    drive(32'hFFFFFFFF);
    rd(5'h00, d); chk("R2 all", d, 32'h787FFFFF);
    chk_outs("R6 all R12");
    drive(32'h0);
    rd(5'h00, d); chk("R2 drop", d, 0);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    drive(32'h00F0_FF80);
    wr(5'h0C, 32'hFFFFFFFF);
    rd(5'h04, d); chk("R5 read", d, 32'hF05DFF80);
    rd(5'h00, d); chk("R4 pend kept", d, 32'h00F0FF80 & 32'h787FFFFF);
    chk_outs("R9 master");
    wr(5'h08, 32'h0000_FF00);
    rd(5'h04, d); chk("R3 partial", d, 32'hF05D0080);
    chk_outs("R9 still off");
    wr(5'h08, 32'h8000_0000);
    chk_outs("R3 R6 partial");
    wr(5'h0C, 32'h0000_0C00);
    rd(5'h04, d); chk("R4 set", d, 32'h705D0C80);
    chk_outs("R4 lvl");
    wr(5'h00, 32'hFFFFFFFF);
    wr(5'h04, 32'hFFFFFFFF);
    wr(5'h14, 32'hFFFFFFFF);
    rd(5'h04, d); chk("R11 ro", d, 32'h705D0C80);
    rd(5'h10, d); chk("R11 tgt", d, {28'h0, m_tgt});
    rd(5'h18, d); chk("R11 unmapped", d, 0);
    rd(5'h1C, d); chk("R11 unmapped", d, 0);
    wr(5'h08, 32'hFFFFFFFF);
  endtask

  task automatic t_target;
    logic [31:0] d;
    drive(32'h7010_8000);
    wr(5'h10, 32'hABC2);
    rd(5'h10, d); chk("R8 low bits", d, 2);
    chk_outs("R7 cpu2");
    wr(5'h10, 32'h3);
    chk_outs("R7 cpu3");
    wr(5'h10, 32'h9);
    chk_outs("R7 none");
    chk("R7 none zero", cpu_lvl, 0);
    wr(5'h10, 32'h1);
    wr(5'h0C, 32'h8000_0000);
    chk_outs("R10 bcast masked");
    chk("R10 bcast", lvl15_bcast, {NCPU{1'b1}});
    drive(32'h0);
    chk("R10 off", lvl15_bcast, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_dis = 32'h0FA2007F; m_tgt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_mask();
    t_target();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule